// File: doc/BRIEF.md
# Store Buffer with Ordering Mode and Fence

The block sits between a processor's load/store port and a single memory port that answers with a request/acknowledge handshake of variable latency. In relaxed mode the processor hands a store to a small FIFO and moves on in the same cycle. The FIFO then writes its entries to memory in age order, one access at a time. A load whose address is still held in the FIFO takes the youngest held value at once. A load that finds no match goes to memory ahead of the stores still waiting.

In sequentially consistent mode nothing overtakes anything. Every load or store waits until the FIFO is empty and the memory port is idle. It then goes to memory itself, and the processor sees it complete only when memory acknowledges it. In either mode a fence request is held until the FIFO is empty and no write is in flight. Software uses fences around lock acquire and release, so that writes made inside a critical section reach memory before the release does.

The processor holds its request and fields steady until `cpu_ready_o` is high in a cycle. A request completes at that clock edge.

Top module: `sbuf_fence`

## Requirements
- R1: After reset the buffer is empty, `mem_req_o` is low, and `cpu_ready_o` stays low while no request is presented.
- R2: In relaxed mode (`sc_mode_i`=0), a store (`cpu_we_i`=1, `cpu_fence_i`=0) is accepted in the cycle it is presented whenever the buffer holds fewer than DEPTH entries, whatever the memory side is doing.
- R3: In relaxed mode, a store presented while DEPTH entries are held is stalled until an entry has drained, and the occupancy never exceeds DEPTH.
- R4: Held stores are written to memory (`mem_we_o`=1) in the order they were accepted, with one memory access outstanding at a time.
- R5: In relaxed mode, a load (`cpu_we_i`=0) whose address matches a held store completes in the cycle it is presented, returns the data of the youngest matching store, and issues no memory read.
- R6: In relaxed mode, a load with no matching held store is sent to memory as soon as the port is free, ahead of the stores still held.
- R7: In sequentially consistent mode (`sc_mode_i`=1), a load or store is issued to memory only once the buffer is empty and the port is idle, and it completes only in the cycle memory acknowledges it.
- R8: A fence (`cpu_fence_i`=1) completes only in a cycle when the buffer is empty and no memory access is outstanding; on an idle, empty buffer it completes at once.
- R9: Once `mem_req_o` is raised, it and the address, data and direction are held steady until `mem_ack_i`; a direct access completes L+1 cycles after it is presented when memory acknowledges after L waiting cycles.
- R10: A load served by memory returns `mem_rdata_i` on `cpu_rdata_o` in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sc_mode_i | input | 1 | 1 = sequentially consistent, 0 = relaxed buffering |
| cpu_req_i | input | 1 | Processor request valid, held until ready |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_fence_i | input | 1 | Request is a fence; overrides cpu_we_i |
| cpu_addr_i | input | AW | Access address |
| cpu_wdata_i | input | DW | Store data |
| cpu_ready_o | output | 1 | Request completes at this clock edge |
| cpu_rdata_o | output | DW | Load data, valid with ready for loads |
| mem_req_o | output | 1 | Memory access outstanding |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_ack_i | input | 1 | Memory completes the outstanding access |
| mem_rdata_i | input | DW | Memory read data, valid with ack |

## Verification
Relaxed stores are pushed into a slow memory until the buffer is full. This separates acceptance without waiting from a real full stall, and the memory log then shows whether the drain kept FIFO order. Loads are tried against repeated addresses, against addresses not held, and after a switch from relaxed to sequentially consistent mode with stores still held. Together these separate youngest-match forwarding, bypassing of held stores, and waiting for the drain. Latency is swept from zero upward for direct loads and stores in both modes, so an off-by-one in completion timing or in the stability of the request shows up as a wrong wait count or wrong data. Fences are issued both on an empty buffer and behind pending writes.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  typedef enum logic [1:0] {
    PS_IDLE   = 2'd0,
    PS_DRAIN  = 2'd1,
    PS_DIRECT = 2'd2
  } port_state_e;
endpackage

// File: rtl/sbuf_queue.sv
module sbuf_queue #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic [AW-1:0]              push_addr_i,
  input  logic [DW-1:0]              push_data_i,
  input  logic                       pop_i,
  output logic [AW-1:0]              head_addr_o,
  output logic [DW-1:0]              head_data_o,
  output logic [CNT_W-1:0]           occ_o,
  output logic [DEPTH-1:0][AW-1:0]   ent_addr_o,
  output logic [DEPTH-1:0][DW-1:0]   ent_data_o,
  output logic [DEPTH-1:0]           ent_vld_o
);
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] occ_q;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      if (push_i) tail_q <= ptr_next(tail_q);
      if (pop_i)  head_q <= ptr_next(head_q);
      if (push_i && !pop_i)      occ_q <= occ_q + 1'b1;
      else if (pop_i && !push_i) occ_q <= occ_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[tail_q] <= push_addr_i;
      data_q[tail_q] <= push_data_i;
    end
  end

  assign head_addr_o = addr_q[head_q];
  assign head_data_o = data_q[head_q];
  assign occ_o       = occ_q;

  // entries presented oldest first
  for (genvar i = 0; i < DEPTH; i++) begin : g_age
    logic [PTR_W:0]   sum;
    logic [PTR_W-1:0] idx;
    assign sum = {1'b0, head_q} + (PTR_W+1)'(i);
    assign idx = (sum >= (PTR_W+1)'(DEPTH)) ? PTR_W'(sum - (PTR_W+1)'(DEPTH)) : PTR_W'(sum);
    assign ent_addr_o[i] = addr_q[idx];
    assign ent_data_o[i] = data_q[idx];
    assign ent_vld_o[i]  = occ_q > CNT_W'(i);
  end
endmodule

// File: rtl/sbuf_match.sv
module sbuf_match #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 16
) (
  input  logic [DEPTH-1:0][AW-1:0] ent_addr_i,
  input  logic [DEPTH-1:0][DW-1:0] ent_data_i,
  input  logic [DEPTH-1:0]         ent_vld_i,
  input  logic [AW-1:0]            look_addr_i,
  output logic                     hit_o,
  output logic [DW-1:0]            data_o
);
  logic [DEPTH-1:0] hit_v;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_v[i] = ent_vld_i[i] && (ent_addr_i[i] == look_addr_i);
  end

  // youngest match wins: later index overrides
  always_comb begin
    data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_v[i]) data_o = ent_data_i[i];
    end
  end

  assign hit_o = |hit_v;
endmodule

// File: rtl/sbuf_fence.sv
module sbuf_fence
  import sbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sc_mode_i,
  input  logic          cpu_req_i,
  input  logic          cpu_we_i,
  input  logic          cpu_fence_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic          cpu_ready_o,
  output logic [DW-1:0] cpu_rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  port_state_e state_q, state_d;

  logic [CNT_W-1:0]         occ;
  logic [AW-1:0]            head_addr;
  logic [DW-1:0]            head_data;
  logic [DEPTH-1:0][AW-1:0] ent_addr;
  logic [DEPTH-1:0][DW-1:0] ent_data;
  logic [DEPTH-1:0]         ent_vld;
  logic                     fwd_hit;
  logic [DW-1:0]            fwd_data;

  logic          dir_we_q;
  logic [AW-1:0] dir_addr_q;
  logic [DW-1:0] dir_data_q;

  logic is_fence, is_st, is_ld, empty, full, idle;
  logic st_buffer, ld_fwd, direct_ok, direct_done, pop, fence_ok;

  assign is_fence = cpu_req_i && cpu_fence_i;
  assign is_st    = cpu_req_i && !cpu_fence_i && cpu_we_i;
  assign is_ld    = cpu_req_i && !cpu_fence_i && !cpu_we_i;
  assign empty    = (occ == '0);
  assign full     = (occ == CNT_W'(DEPTH));
  assign idle     = (state_q == PS_IDLE);

  assign st_buffer   = is_st && !sc_mode_i && !full;
  assign ld_fwd      = is_ld && !sc_mode_i && fwd_hit;
  assign direct_ok   = idle && (sc_mode_i ? (empty && (is_st || is_ld))
                                          : (is_ld && !fwd_hit));
  assign direct_done = (state_q == PS_DIRECT) && mem_ack_i;
  assign pop         = (state_q == PS_DRAIN) && mem_ack_i;
  assign fence_ok    = is_fence && empty && idle;

  assign cpu_ready_o = st_buffer || ld_fwd || direct_done || fence_ok;
  assign cpu_rdata_o = direct_done ? mem_rdata_i : fwd_data;

  sbuf_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (st_buffer),
    .push_addr_i (cpu_addr_i),
    .push_data_i (cpu_wdata_i),
    .pop_i       (pop),
    .head_addr_o (head_addr),
    .head_data_o (head_data),
    .occ_o       (occ),
    .ent_addr_o  (ent_addr),
    .ent_data_o  (ent_data),
    .ent_vld_o   (ent_vld)
  );

  sbuf_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
    .ent_addr_i  (ent_addr),
    .ent_data_i  (ent_data),
    .ent_vld_i   (ent_vld),
    .look_addr_i (cpu_addr_i),
    .hit_o       (fwd_hit),
    .data_o      (fwd_data)
  );

  // a direct access from the processor wins the idle port over draining
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_IDLE: begin
        if (direct_ok)   state_d = PS_DIRECT;
        else if (!empty) state_d = PS_DRAIN;
      end
      PS_DRAIN, PS_DIRECT: if (mem_ack_i) state_d = PS_IDLE;
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= PS_IDLE;
      dir_we_q   <= 1'b0;
      dir_addr_q <= '0;
      dir_data_q <= '0;
    end else begin
      state_q <= state_d;
      if (direct_ok) begin
        dir_we_q   <= cpu_we_i;
        dir_addr_q <= cpu_addr_i;
        dir_data_q <= cpu_wdata_i;
      end
    end
  end

  assign mem_req_o   = (state_q != PS_IDLE);
  assign mem_we_o    = (state_q == PS_DRAIN) ? 1'b1 : dir_we_q;
  assign mem_addr_o  = (state_q == PS_DRAIN) ? head_addr : dir_addr_q;
  assign mem_wdata_o = (state_q == PS_DRAIN) ? head_data : dir_data_q;
endmodule

// File: rtl/sbuf_fence_chk.sv
module sbuf_fence_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sc_mode_i,
  input logic             cpu_req_i,
  input logic             cpu_we_i,
  input logic             cpu_fence_i,
  input logic             cpu_ready_o,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [AW-1:0]    mem_addr_o,
  input logic [DW-1:0]    mem_wdata_o,
  input logic             mem_ack_i,
  input logic [CNT_W-1:0] occ
);
  a_r9_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                                && $stable(mem_we_o) && $stable(mem_wdata_o));

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= CNT_W'(DEPTH));

  a_r7_sc_read_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) && !mem_we_o && sc_mode_i && $stable(sc_mode_i) |-> occ == '0);

  a_r8_fence_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_fence_i && cpu_ready_o |-> !mem_req_o && occ == '0);

  a_r5_fwd_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && !cpu_fence_i && !cpu_we_i && !sc_mode_i && cpu_ready_o && !mem_ack_i
    |-> !(mem_req_o && !mem_we_o));

  a_r2_push_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_we_i && !cpu_fence_i && !sc_mode_i && cpu_ready_o
    && !(mem_req_o && mem_ack_i) |=> occ == $past(occ) + 1'b1);

  a_r4_single_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_ack_i |=> occ <= $past(occ));
endmodule

bind sbuf_fence sbuf_fence_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sc_mode_i   (sc_mode_i),
  .cpu_req_i   (cpu_req_i),
  .cpu_we_i    (cpu_we_i),
  .cpu_fence_i (cpu_fence_i),
  .cpu_ready_o (cpu_ready_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .occ         (occ)
);

// File: tb/sbuf_fence_bench.sv
`timescale 1ns/1ps
module sbuf_fence_bench;
  localparam int DEPTH = 4;
  localparam int AW    = 8;
  localparam int DW    = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sc_mode;
  logic          cpu_req, cpu_we, cpu_fence;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata;
  logic          cpu_ready_o;
  logic [DW-1:0] cpu_rdata_o;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic          mem_ack;
  logic [DW-1:0] mem_rdata;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int cnt = 0;

  logic [DW-1:0] mem_model [256];
  logic          log_we   [64];
  logic [AW-1:0] log_addr [64];
  logic [DW-1:0] log_data [64];
  int            log_n = 0;

  always #5 clk = ~clk;

  sbuf_fence #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_sbuf_fence (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sc_mode_i   (sc_mode),
    .cpu_req_i   (cpu_req),
    .cpu_we_i    (cpu_we),
    .cpu_fence_i (cpu_fence),
    .cpu_addr_i  (cpu_addr),
    .cpu_wdata_i (cpu_wdata),
    .cpu_ready_o (cpu_ready_o),
    .cpu_rdata_o (cpu_rdata_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack),
    .mem_rdata_i (mem_rdata)
  );

  function automatic logic [DW-1:0] init_val(input int a);
    return DW'(a * 3 + 7);
  endfunction

  // memory model: ack after lat waiting cycles, one cycle wide
  initial begin
    mem_ack   = 1'b0;
    mem_rdata = '0;
    for (int i = 0; i < 256; i++) mem_model[i] = init_val(i);
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        cnt = 0;
      end else if (rst_n && mem_req_o) begin
        if (cnt >= lat) begin
          mem_ack = 1'b1;
          if (mem_we_o) mem_model[mem_addr_o] = mem_wdata_o;
          else          mem_rdata = mem_model[mem_addr_o];
          if (log_n < 64) begin
            log_we[log_n]   = mem_we_o;
            log_addr[log_n] = mem_addr_o;
            log_data[log_n] = mem_we_o ? mem_wdata_o : mem_model[mem_addr_o];
          end
          log_n++;
        end else begin
          cnt++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic op(input logic we, input logic fence, input int a, input int d,
                    output int waits, output int rd);
    @(negedge clk);
    cpu_req   = 1'b1;
    cpu_we    = we;
    cpu_fence = fence;
    cpu_addr  = AW'(a);
    cpu_wdata = DW'(d);
    waits = 0;
    rd = 0;
    forever begin
      #1;
      if (cpu_ready_o) begin
        rd = int'(cpu_rdata_o);
        break;
      end
      waits++;
      if (waits > 400) break;
      @(negedge clk);
    end
    @(posedge clk);
  endtask

  task automatic quiet(input logic sc);
    @(negedge clk);
    cpu_req = 1'b0;
    sc_mode = sc;
  endtask

  function automatic int writes_since(input int base);
    int n = 0;
    for (int i = base; i < log_n && i < 64; i++) if (log_we[i]) n++;
    return n;
  endfunction

  function automatic int reads_since(input int base);
    int n = 0;
    for (int i = base; i < log_n && i < 64; i++) if (!log_we[i]) n++;
    return n;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int w, r, base;
    rst_n = 1'b0; sc_mode = 1'b0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_fence = 1'b0;
    cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(mem_req_o == 1'b0, "R1 mem_req after reset", int'(mem_req_o), 0);
    chk(cpu_ready_o == 1'b0, "R1 ready idle", int'(cpu_ready_o), 0);

    // R8: fence on an empty, idle buffer
    op(1'b0, 1'b1, 0, 0, w, r);
    chk(w == 0, "R8 fence on empty", w, 0);

    // R2/R3/R4: fill a slow buffer, overflow it, drain in order
    lat = 8;
    base = log_n;
    for (int k = 0; k < DEPTH; k++) begin
      op(1'b1, 1'b0, 'h10 + k, 'h100 + k, w, r);
      chk(w == 0, "R2 store accepted at once", w, 0);
    end
    op(1'b1, 1'b0, 'h10 + DEPTH, 'h100 + DEPTH, w, r);
    chk(w > 0, "R3 store stalled when full", w, 1);
    chk(w < 400, "R3 stalled store later accepted", w, 399);
    op(1'b0, 1'b1, 0, 0, w, r);
    chk(w > 0, "R8 fence waits for drain", w, 1);
    chk(writes_since(base) == DEPTH + 1, "R8 all writes done at fence", writes_since(base), DEPTH + 1);
    for (int k = 0; k <= DEPTH; k++) begin
      chk(log_we[base+k] && int'(log_addr[base+k]) == 'h10 + k && int'(log_data[base+k]) == 'h100 + k,
          "R4 drain order", int'(log_addr[base+k]), 'h10 + k);
    end

    // R5: youngest-match forwarding, no memory read
    lat = 30;
    base = log_n;
    op(1'b1, 1'b0, 'h20, 'hA1, w, r);
    op(1'b1, 1'b0, 'h21, 'hB1, w, r);
    op(1'b1, 1'b0, 'h20, 'hA2, w, r);
    op(1'b0, 1'b0, 'h20, 0, w, r);
    chk(w == 0 && r == 'hA2, "R5 youngest of two", r, 'hA2);
    op(1'b0, 1'b0, 'h21, 0, w, r);
    chk(w == 0 && r == 'hB1, "R5 single match", r, 'hB1);
    op(1'b1, 1'b0, 'h20, 'hA3, w, r);
    op(1'b0, 1'b0, 'h20, 0, w, r);
    chk(w == 0 && r == 'hA3, "R5 youngest of three", r, 'hA3);
    chk(reads_since(base) == 0, "R5 no memory read", reads_since(base), 0);
    op(1'b0, 1'b1, 0, 0, w, r);
    chk(int'(mem_model['h20]) == 'hA3, "R4 last store to address wins", int'(mem_model['h20]), 'hA3);

    // R6: load miss bypasses held stores
    lat = 10;
    base = log_n;
    op(1'b1, 1'b0, 'h30, 'h301, w, r);
    op(1'b1, 1'b0, 'h31, 'h311, w, r);
    op(1'b1, 1'b0, 'h32, 'h321, w, r);
    op(1'b0, 1'b0, 'h40, 0, w, r);
    chk(r == int'(init_val('h40)), "R6 miss data from memory", r, int'(init_val('h40)));
    chk(writes_since(base) == 1, "R6 load ahead of held stores", writes_since(base), 1);
    op(1'b0, 1'b1, 0, 0, w, r);
    chk(writes_since(base) == 3, "R8 remaining stores drained", writes_since(base), 3);

    // R7/R9/R10: sequentially consistent direct accesses, latency sweep
    quiet(1'b1);
    for (int l = 0; l < 5; l++) begin
      lat = l;
      op(1'b1, 1'b0, 'h50 + l, 'h500 + l, w, r);
      chk(w == l + 1, "R7 sc store completes at ack", w, l + 1);
      chk(log_we[log_n-1] && int'(log_addr[log_n-1]) == 'h50 + l,
          "R7 sc store in memory at completion", int'(log_addr[log_n-1]), 'h50 + l);
      op(1'b0, 1'b0, 'h50 + l, 0, w, r);
      chk(w == l + 1, "R9 sc load latency", w, l + 1);
      chk(r == 'h500 + l, "R10 sc load data", r, 'h500 + l);
    end

    // R7: switch to sc with stores still held
    quiet(1'b0);
    lat = 5;
    base = log_n;
    op(1'b1, 1'b0, 'h60, 'h601, w, r);
    op(1'b1, 1'b0, 'h61, 'h611, w, r);
    quiet(1'b1);
    op(1'b0, 1'b0, 'h60, 0, w, r);
    chk(r == 'h601, "R7 sc load sees drained store", r, 'h601);
    chk(writes_since(base) == 2, "R7 sc load after all writes", writes_since(base), 2);
    chk(!log_we[log_n-1], "R7 read issued last", int'(log_we[log_n-1]), 0);

    // R9/R10: relaxed load miss latency sweep
    quiet(1'b0);
    for (int l = 0; l < 6; l++) begin
      lat = l;
      op(1'b0, 1'b0, 'h70 + l, 0, w, r);
      chk(w == l + 1, "R9 relaxed miss latency", w, l + 1);
      chk(r == int'(init_val('h70 + l)), "R10 relaxed miss data", r, int'(init_val('h70 + l)));
    end

    quiet(1'b0);
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule